// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates among five interrupt request flags: two external lines, two timer overflow flags and one serial port flag. It then issues one vector request at a time to a CPU core. Software programs two byte-wide registers over a simple special-function-register bus. The enable register holds one enable bit per source and a global enable bit. The level register gives each source one of two priority levels.

Request flags are registered on one clock and arbitrated on the next. One clock stands for one machine cycle. A grant raises `vec_req_o` for a single cycle, together with the vector address and the granted level. On the same edge, the controller marks that level as in service. A high-level request can interrupt a low-level routine. Any other request waits until the core pulses `reti_i`. That pulse retires the highest level currently in service.

Top module: `intc_top`

## Requirements
- R1: After reset, both registers read 0x00, `vec_req_o` is 0 and `ins_o` is 2'b00.
- R2: The enable register sits at address 0xA8. Bits 0..4 enable external 0, timer 0, external 1, timer 1 and serial, and bit 7 is the global enable. Bits 5 and 6 always read 0, and writes to them are ignored. The level register sits at 0xB8: bits 0..4 select high level (1) per source in the same order, and bits 5..7 read 0. Any other address reads 0x00.
- R3: A source is granted only while its own enable bit and the global bit are both 1. With the global bit at 0, no request is issued.
- R4: A flag that is present at clock edge k is sampled at edge k and can be granted at edge k+1 at the earliest.
- R5: Among requests eligible at the same level, the order is external 0, timer 0, external 1, timer 1, serial.
- R6: When eligible requests exist at both levels, a high-level source wins.
- R7: While only the low level is in service, a high-level request is granted and both `ins_o` bits are then 1.
- R8: A request is not granted while its own level or a higher level is in service.
- R9: Vector addresses are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023 in source order.
- R10: A `reti_i` pulse clears the high in-service bit if it is set, and otherwise clears the low bit.
- R11: Each grant raises `vec_req_o` for exactly one cycle. In that same cycle, `ins_o` shows the granted level as in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one machine cycle per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data, combinational from address |
| irq_i | input | 5 | Request flags, bit 0 external 0 to bit 4 serial |
| reti_i | input | 1 | Return-from-interrupt pulse |
| vec_req_o | output | 1 | Vector request pulse |
| vec_lvl_o | output | 1 | Level of the granted request, 1 for high |
| vec_addr_o | output | 16 | Vector address of the last grant |
| ins_o | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
On every cycle, the assertions check the following properties:
- A grant never appears while its own level or a higher level was already in service.
- Every grant leaves its level marked in service.
- Every grant uses a legal vector address.
- No grant appears while the global enable is off.
- A return pulse always retires the high level when that level is set.
- The unimplemented enable bits always read 0.

The bench scenarios cover the properties that need stimulus histories:
- The one-cycle sampling delay.
- The fixed order inside a level, shown by draining five simultaneous requests one return at a time.
- A high level winning over a low level when both request together.
- A low-level routine being preempted while a blocked request stays pending until two returns.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  typedef struct packed {
    logic             valid;
    lvl_e             lvl;
    logic [SRC_W-1:0] idx;
  } grant_t;
endpackage

// File: rtl/intc_sfr.sv
module intc_sfr
  import intc_pkg::*;
#(
  parameter int unsigned        DW       = 8,
  parameter int unsigned        AW       = 8,
  parameter logic [AW-1:0]      EN_ADDR  = 8'hA8,
  parameter logic [AW-1:0]      PRI_ADDR = 8'hB8,
  parameter int unsigned        GE_BIT   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NUM_SRC-1:0] src_en_o,
  output logic               glb_en_o,
  output logic [NUM_SRC-1:0] pri_o
);
  localparam logic [DW-1:0] SRC_MASK = DW'((1 << NUM_SRC) - 1);
  localparam logic [DW-1:0] EN_MASK  = SRC_MASK | DW'(1 << GE_BIT);

  logic [DW-1:0] en_q, pri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (wr_i) begin
      if (addr_i == EN_ADDR)  en_q  <= wdata_i & EN_MASK;
      if (addr_i == PRI_ADDR) pri_q <= wdata_i & SRC_MASK;
    end
  end

  always_comb begin
    if (addr_i == EN_ADDR)       rdata_o = en_q;
    else if (addr_i == PRI_ADDR) rdata_o = pri_q;
    else                         rdata_o = '0;
  end

  assign src_en_o = en_q[NUM_SRC-1:0];
  assign glb_en_o = en_q[GE_BIT];
  assign pri_o    = pri_q[NUM_SRC-1:0];
endmodule

// File: rtl/intc_sample.sv
module intc_sample
  import intc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [NUM_SRC-1:0] flag_o
);
  // one cycle of sampling before arbitration acts on a flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= irq_i;
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
(
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] pri_i,
  input  logic [1:0]         ins_i,
  output grant_t             grant_o
);
  localparam int unsigned NLVL = 2;

  logic [NUM_SRC-1:0] live;
  logic [NLVL-1:0][NUM_SRC-1:0] elig;
  logic [NLVL-1:0]              any;
  logic [NLVL-1:0][SRC_W-1:0]   pick;
  logic [NLVL-1:0]              open_lvl;

  assign live = flag_i & src_en_i & {NUM_SRC{glb_en_i}};
  assign elig[LVL_HI] = live & pri_i;
  assign elig[LVL_LO] = live & ~pri_i;

  // high may enter unless high in service; low only when nothing is
  assign open_lvl[LVL_HI] = ~ins_i[LVL_HI];
  assign open_lvl[LVL_LO] = ~|ins_i;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    always_comb begin
      pick[l] = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (elig[l][i]) pick[l] = SRC_W'(i);
      end
    end
    assign any[l] = |elig[l] & open_lvl[l];
  end

  always_comb begin
    grant_o = '{valid: 1'b0, lvl: LVL_LO, idx: '0};
    if (any[LVL_HI]) begin
      grant_o = '{valid: 1'b1, lvl: LVL_HI, idx: pick[LVL_HI]};
    end else if (any[LVL_LO] && ~|elig[LVL_HI]) begin
      grant_o = '{valid: 1'b1, lvl: LVL_LO, idx: pick[LVL_LO]};
    end
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest
  import intc_pkg::*;
#(
  parameter int unsigned          VA_W       = 16,
  parameter logic [VA_W-1:0]      VEC_BASE   = 16'h0003,
  parameter int unsigned          VEC_STRIDE = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  grant_t          grant_i,
  input  logic            reti_i,
  output logic [1:0]      ins_o,
  output logic            vec_req_o,
  output logic            vec_lvl_o,
  output logic [VA_W-1:0] vec_addr_o
);
  logic [1:0] clr, set, ins_q;

  always_comb begin
    clr = 2'b00;
    if (reti_i) begin
      if (ins_q[LVL_HI])      clr = 2'b10;
      else if (ins_q[LVL_LO]) clr = 2'b01;
    end
    set = 2'b00;
    if (grant_i.valid) set[grant_i.lvl] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q      <= '0;
      vec_req_o  <= 1'b0;
      vec_lvl_o  <= 1'b0;
      vec_addr_o <= '0;
    end else begin
      ins_q     <= (ins_q & ~clr) | set;
      vec_req_o <= grant_i.valid;
      if (grant_i.valid) begin
        vec_lvl_o  <= grant_i.lvl;
        vec_addr_o <= VEC_BASE + VA_W'(grant_i.idx) * VA_W'(VEC_STRIDE);
      end
    end
  end

  assign ins_o = ins_q;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int unsigned     DW         = 8,
  parameter int unsigned     AW         = 8,
  parameter logic [AW-1:0]   EN_ADDR    = 8'hA8,
  parameter logic [AW-1:0]   PRI_ADDR   = 8'hB8,
  parameter int unsigned     GE_BIT     = 7,
  parameter int unsigned     VA_W       = 16,
  parameter logic [VA_W-1:0] VEC_BASE   = 16'h0003,
  parameter int unsigned     VEC_STRIDE = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sfr_wr_i,
  input  logic [AW-1:0]   sfr_addr_i,
  input  logic [DW-1:0]   sfr_wdata_i,
  output logic [DW-1:0]   sfr_rdata_o,
  input  logic [4:0]      irq_i,
  input  logic            reti_i,
  output logic            vec_req_o,
  output logic            vec_lvl_o,
  output logic [VA_W-1:0] vec_addr_o,
  output logic [1:0]      ins_o
);
  logic [NUM_SRC-1:0] src_en, pri, flag;
  logic               glb_en;
  grant_t             grant;

  intc_sfr #(
    .DW(DW), .AW(AW), .EN_ADDR(EN_ADDR), .PRI_ADDR(PRI_ADDR), .GE_BIT(GE_BIT)
  ) u_sfr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sfr_wr_i),
    .addr_i   (sfr_addr_i),
    .wdata_i  (sfr_wdata_i),
    .rdata_o  (sfr_rdata_o),
    .src_en_o (src_en),
    .glb_en_o (glb_en),
    .pri_o    (pri)
  );

  intc_sample u_sample (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .flag_o (flag)
  );

  intc_arb u_arb (
    .flag_i   (flag),
    .src_en_i (src_en),
    .glb_en_i (glb_en),
    .pri_i    (pri),
    .ins_i    (ins_o),
    .grant_o  (grant)
  );

  intc_nest #(
    .VA_W(VA_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_nest (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .reti_i     (reti_i),
    .ins_o      (ins_o),
    .vec_req_o  (vec_req_o),
    .vec_lvl_o  (vec_lvl_o),
    .vec_addr_o (vec_addr_o)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter logic [7:0]  EN_ADDR    = 8'hA8,
  parameter int unsigned VA_W       = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter int unsigned NUM_SRC    = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reti_i,
  input logic            vec_req_i,
  input logic            vec_lvl_i,
  input logic [VA_W-1:0] vec_addr_i,
  input logic [1:0]      ins_i,
  input logic            glb_en_i,
  input logic [AW-1:0]   sfr_addr_i,
  input logic [DW-1:0]   sfr_rdata_i
);
  AST_GRANT_MARKS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_i |-> ins_i[vec_lvl_i]); // R11

  AST_NO_GRANT_UNDER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_i |-> !$past(ins_i[1])); // R8

  AST_LOW_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_i && !vec_lvl_i) |-> ($past(ins_i) == 2'b00)); // R8

  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_i |-> (int'(vec_addr_i) >= int'(VEC_BASE)
                   && ((int'(vec_addr_i) - int'(VEC_BASE)) % int'(VEC_STRIDE)) == 0
                   && (int'(vec_addr_i) - int'(VEC_BASE)) < int'(NUM_SRC * VEC_STRIDE))); // R9

  AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_i |-> $past(glb_en_i)); // R3

  AST_RETI_HIGH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && ins_i[1]) |=> !ins_i[1]); // R10

  AST_EN_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == AW'(EN_ADDR)) |-> (sfr_rdata_i[6:5] == 2'b00)); // R2
endmodule

bind intc_top intc_chk #(
  .AW(AW), .DW(DW), .EN_ADDR(8'(EN_ADDR)), .VA_W(VA_W),
  .VEC_BASE(int'(VEC_BASE)), .VEC_STRIDE(VEC_STRIDE), .NUM_SRC(intc_pkg::NUM_SRC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reti_i      (reti_i),
  .vec_req_i   (vec_req_o),
  .vec_lvl_i   (vec_lvl_o),
  .vec_addr_i  (vec_addr_o),
  .ins_i       (ins_o),
  .glb_en_i    (glb_en),
  .sfr_addr_i  (sfr_addr_i),
  .sfr_rdata_i (sfr_rdata_o)
);

// File: tb/intc_top_tb_top.sv
`timescale 1ns/1ps
module intc_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sfr_wr_i = 1'b0;
  logic [7:0]  sfr_addr_i = 8'h00;
  logic [7:0]  sfr_wdata_i = 8'h00;
  logic [7:0]  sfr_rdata_o;
  logic [4:0]  irq_i = 5'h00;
  logic        reti_i = 1'b0;
  logic        vec_req_o;
  logic        vec_lvl_o;
  logic [15:0] vec_addr_o;
  logic [1:0]  ins_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  intc_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sfr_wr_i(sfr_wr_i), .sfr_addr_i(sfr_addr_i),
    .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o), .irq_i(irq_i),
    .reti_i(reti_i), .vec_req_o(vec_req_o), .vec_lvl_o(vec_lvl_o),
    .vec_addr_o(vec_addr_o), .ins_o(ins_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit [7:0] m_en, m_pri;
  bit [4:0] m_flag;
  bit [1:0] m_ins;
  bit       m_req, m_lvl;
  int       m_addr;

  always @(posedge clk_i) begin
    int win, wl, clr;
    cyc++;
    if (!rst_ni) begin
      m_en = 0; m_pri = 0; m_flag = 0; m_ins = 0; m_req = 0; m_lvl = 0; m_addr = 0;
    end else begin
      win = -1; wl = 0;
      for (int i = 0; i < 5; i++)
        if (win < 0 && m_flag[i] && m_en[i] && m_en[7] && m_pri[i] && !m_ins[1]) begin
          win = i; wl = 1;
        end
      for (int i = 0; i < 5; i++)
        if (win < 0 && m_flag[i] && m_en[i] && m_en[7] && !m_pri[i] && m_ins == 0) begin
          win = i; wl = 0;
        end
      clr = 0;
      if (reti_i) clr = m_ins[1] ? 2 : (m_ins[0] ? 1 : 0);
      m_ins = (m_ins & ~2'(clr)) | ((win >= 0) ? 2'(1 << wl) : 2'b00);
      m_req = (win >= 0);
      if (win >= 0) begin
        m_addr = 3 + 8 * win;
        m_lvl  = 1'(wl);
      end
      if (sfr_wr_i && sfr_addr_i == 8'hA8) m_en  = sfr_wdata_i & 8'h9F;
      if (sfr_wr_i && sfr_addr_i == 8'hB8) m_pri = sfr_wdata_i & 8'h1F;
      m_flag = irq_i;
    end
  end

  // compare every cycle, before drivers move at +5
  always @(posedge clk_i) begin
    #3;
    if (rst_ni) begin
      check("R4 model vec_req", int'(vec_req_o), int'(m_req));
      check("R10 model ins", int'(ins_o), int'(m_ins));
      if (m_req) begin
        check("R9 model vec_addr", int'(vec_addr_o), m_addr);
        check("R6 model vec_lvl", int'(vec_lvl_o), int'(m_lvl));
      end
      check("R2 model rdata", int'(sfr_rdata_o),
            sfr_addr_i == 8'hA8 ? int'(m_en) : (sfr_addr_i == 8'hB8 ? int'(m_pri) : 0));
    end
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic tick(); @(posedge clk_i); #5; endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    sfr_wr_i = 1; sfr_addr_i = a; sfr_wdata_i = d;
    tick();
    sfr_wr_i = 0;
  endtask

  task automatic rd_chk(input string req, input bit [7:0] a, input int exp);
    sfr_addr_i = a; #1;
    check(req, int'(sfr_rdata_o), exp);
  endtask

  task automatic reti_once();
    reti_i = 1; tick(); reti_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #5 rst_ni = 1;
    tick();
    // R1 reset state
    rd_chk("R1 enable reset", 8'hA8, 0);
    rd_chk("R1 level reset", 8'hB8, 0);
    check("R1 no request", int'(vec_req_o), 0);
    check("R1 ins idle", int'(ins_o), 0);
    // R2 register masks
    wr(8'hA8, 8'hFF); rd_chk("R2 enable gap bits", 8'hA8, 8'h9F);
    wr(8'hB8, 8'hFF); rd_chk("R2 level upper bits", 8'hB8, 8'h1F);
    rd_chk("R2 other address", 8'h42, 0);
    wr(8'hB8, 8'h00);
    // R3 global off blocks all
    wr(8'hA8, 8'h1F);
    irq_i = 5'h1F;
    repeat (3) tick();
    check("R3 global off no request", int'(vec_req_o), 0);
    check("R3 global off ins", int'(ins_o), 0);
    wr(8'hA8, 8'h9F);
    tick();
    check("R5 first grant", int'(vec_req_o), 1);
    check("R9 ext0 vector", int'(vec_addr_o), 16'h0003);
    check("R11 ins marked", int'(ins_o), 1);
    tick();
    check("R11 single pulse", int'(vec_req_o), 0);
    check("R8 low pending blocked", int'(ins_o), 1);
    // R5 drain in fixed order
    for (int s = 0; s < 5; s++) begin
      irq_i[s] = 1'b0;
      reti_once();
      check("R10 reti clears low", int'(ins_o), 0);
      if (s < 4) begin
        tick();
        check("R5 next in order", int'(vec_req_o), 1);
        check("R9 order vector", int'(vec_addr_o), 3 + 8 * (s + 1));
      end
    end
    tick();
    check("R5 drained", int'(vec_req_o), 0);
    // R4 one cycle of sampling
    irq_i = 5'h04;
    tick();
    check("R4 not yet", int'(vec_req_o), 0);
    tick();
    check("R4 granted", int'(vec_req_o), 1);
    check("R9 ext1 vector", int'(vec_addr_o), 16'h0013);
    irq_i = 0; reti_once(); tick();
    // R3 per-source enable
    wr(8'hA8, 8'h9E);
    irq_i = 5'h01;
    repeat (3) tick();
    check("R3 source disabled", int'(vec_req_o), 0);
    check("R3 source disabled ins", int'(ins_o), 0);
    irq_i = 0;
    wr(8'hA8, 8'h9F);
    // R7 preemption
    irq_i = 5'h10;
    tick(); tick();
    check("R9 serial vector", int'(vec_addr_o), 16'h0023);
    irq_i = 0;
    wr(8'hB8, 8'h02);
    irq_i = 5'h02;
    tick(); tick();
    check("R7 preempt request", int'(vec_req_o), 1);
    check("R7 preempt level", int'(vec_lvl_o), 1);
    check("R7 both in service", int'(ins_o), 3);
    irq_i = 5'h01;
    repeat (3) tick();
    check("R8 low waits under high", int'(vec_req_o), 0);
    reti_once();
    check("R10 high retired first", int'(ins_o), 1);
    tick();
    check("R8 low waits under low", int'(vec_req_o), 0);
    reti_once();
    check("R10 low retired", int'(ins_o), 0);
    tick();
    check("R8 released after reti", int'(vec_req_o), 1);
    check("R9 ext0 after release", int'(vec_addr_o), 16'h0003);
    irq_i = 0; reti_once(); tick();
    // R6 high beats low on a tie
    wr(8'hB8, 8'h10);
    irq_i = 5'h11;
    tick(); tick();
    check("R6 high wins", int'(vec_addr_o), 16'h0023);
    check("R6 high level", int'(vec_lvl_o), 1);
    irq_i = 0; reti_once();
    repeat (2) tick();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule